// File: doc/BRIEF.md
# Packet Parity-Sync Byte Encoder

This block sits on a byte-wide transport stream made of 188-byte packets, each opening with the constant sync byte 0x47. It passes every payload byte through unchanged. When a packet's sync byte arrives, the block writes an 8-bit checksum into that slot in place of the sync byte. The checksum is computed over the 187 payload bytes of the packet that came just before. A receiver can then run a sliding check to find packet edges and flag damaged packets, without help from the error-correction layer.

Payload bits feed a serial division register one byte per cycle. The bits are taken in order from the MSB down. A sync byte closes the window. The block then stalls its input for eight cycles. In that time it shifts zeros through the divider, runs the eight syndrome bits through a second-stage filter, and adds a fixed offset. The result leaves with the start-of-packet marker, MSB first. The whole 1504-bit window, payload plus checksum, therefore decodes to 0x47 under a zero-offset syndrome check. The first sync byte after reset has no preceding payload, so it is passed on as it is.

Top module: `pkt_parity_sync_enc`

## Requirements
- R1: While reset is held, and in the first cycle after it is released, `out_valid` is 0 and `in_ready` is 1.
- R2: An accepted byte with `in_sop` = 0 appears on `out_data` one cycle later, unchanged, with `out_valid` = 1 and `out_sop` = 0.
- R3: The first byte with `in_sop` = 1 accepted after reset is emitted unchanged (0x47) one cycle later, with `out_sop` = 1. `in_ready` stays 1.
- R4: Every later accepted byte with `in_sop` = 1 drops `in_ready` for exactly 8 cycles. In the cycle `in_ready` returns to 1, the checksum appears with `out_valid` = 1 and `out_sop` = 1.
- R5: The checksum is computed in five steps:
  - The payload bits x0..x1495 (MSB of each byte first) go through the filter (1 + X^1497·(1+X+X^3+X^7)) / (1+X+X^5+X^6+X^8), starting from a zero state.
  - Eight zero bits follow the payload.
  - The filter outputs at those eight steps are the syndrome bits s0..s7.
  - The syndrome bits pass through a zero-initialised FIR with taps 1+X+X^5+X^6+X^8, giving c0..c7.
  - The result is (c0..c7, c0 as the MSB) XOR 0x67.
  
  An all-zero payload therefore gives 0x67.
- R6: The syndrome of any emitted window of 187 payload bytes plus its checksum equals 0x47. The syndrome is the same filter with zero offset, outputs 1496..1503 read MSB first.
- R7: A checksum depends only on the bytes between the previous start marker and its own. Identical payloads yield identical checksums, whatever packet comes before them or after them.
- R8: A cycle with `in_ready` = 1 and `in_valid` = 0 produces `out_valid` = 0 in the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input byte present |
| in_ready | output | 1 | Block can accept a byte this cycle |
| in_data | input | 8 | Input byte |
| in_sop | input | 1 | Input byte is the packet sync byte |
| out_valid | output | 1 | Output byte present |
| out_data | output | 8 | Output byte (payload or checksum) |
| out_sop | output | 1 | Output byte is the checksum/sync slot |

## Verification
The assertions hold the following on every cycle:
- the exact eight-cycle stall and the checksum that comes out when it ends;
- the one-cycle, unchanged pass-through of payload bytes;
- the untouched first sync byte;
- the absence of output after an idle cycle.

The value of each checksum, the 0x47 decode of each emitted window, the all-zero case and the independence of a checksum from its neighbouring packets can only be shown by the bench's packet scenarios. Those scenarios compare against a bit-serial model of the filter.

// File: rtl/pkt_parity_sync_enc.sv
module pkt_parity_sync_enc #(
  parameter logic [7:0] SYNC_BYTE  = 8'h47,
  parameter logic [7:0] CHK_OFFSET = 8'h67
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       in_valid,
  output logic       in_ready,
  input  logic [7:0] in_data,
  input  logic       in_sop,
  output logic       out_valid,
  output logic [7:0] out_data,
  output logic       out_sop
);

  localparam int TAIL_LEN = 8;
  localparam int KW = $clog2(TAIL_LEN);

  logic          in_tail, started, head_pend;
  logic [KW-1:0] k;
  logic [7:0]    hist, sreg, chk, head;
  logic          u, y, cbit;

  function automatic logic [7:0] div_byte(input logic [7:0] st, input logic [7:0] d);
    logic [7:0] h;
    logic fb;
    h = st;
    for (int i = 7; i >= 0; i--) begin
      fb = d[i] ^ h[0] ^ h[4] ^ h[5] ^ h[7];
      h  = {h[6:0], fb};
    end
    return h;
  endfunction

  function automatic logic tail_in(input logic [7:0] hd, input logic [KW-1:0] kk);
    logic r;
    r = 1'b0;
    for (int d = 1; d <= 4; d++) begin
      if ((d == 1 || d == 2 || d == 4) && int'(kk) >= d)
        r = r ^ hd[7 - (int'(kk) - d)];
    end
    return r;
  endfunction

  assign in_ready = !in_tail;
  assign u    = tail_in(head, k);
  assign y    = u ^ hist[0] ^ hist[4] ^ hist[5] ^ hist[7];
  assign cbit = y ^ sreg[0] ^ sreg[4] ^ sreg[5] ^ sreg[7] ^ CHK_OFFSET[3'd7 - k];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      in_tail   <= 1'b0;
      started   <= 1'b0;
      head_pend <= 1'b0;
      k         <= '0;
      hist      <= '0;
      sreg      <= '0;
      chk       <= '0;
      head      <= '0;
      out_valid <= 1'b0;
      out_sop   <= 1'b0;
      out_data  <= '0;
    end else begin
      out_valid <= 1'b0;
      out_sop   <= 1'b0;
      if (in_tail) begin
        hist           <= {hist[6:0], y};
        sreg           <= {sreg[6:0], y};
        chk[3'd7 - k]  <= cbit;
        k              <= k + 1'b1;
        if (int'(k) == TAIL_LEN - 1) begin
          in_tail   <= 1'b0;
          hist      <= '0;
          out_valid <= 1'b1;
          out_sop   <= 1'b1;
          out_data  <= {chk[7:1], cbit};
        end
      end else if (in_valid) begin
        if (in_sop) begin
          head_pend <= 1'b1;
          if (started) begin
            in_tail <= 1'b1;
            k       <= '0;
            sreg    <= '0;
          end else begin
            started   <= 1'b1;
            hist      <= '0;
            out_valid <= 1'b1;
            out_sop   <= 1'b1;
            out_data  <= in_data;
          end
        end else begin
          out_valid <= 1'b1;
          out_data  <= in_data;
          hist      <= div_byte(hist, in_data);
          if (head_pend) begin
            head      <= in_data;
            head_pend <= 1'b0;
          end
        end
      end
    end
  end

endmodule

// File: rtl/pkt_parity_sync_enc_chk.sv
module pkt_parity_sync_enc_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       in_valid,
  input logic       in_ready,
  input logic [7:0] in_data,
  input logic       in_sop,
  input logic       out_valid,
  input logic [7:0] out_data,
  input logic       out_sop
);
  logic [3:0] low_cnt;
  logic       seen;
  logic       acc;
  assign acc = in_valid && in_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      low_cnt <= '0;
      seen    <= 1'b0;
    end else begin
      low_cnt <= in_ready ? 4'd0 : low_cnt + 4'd1;
      if (acc && in_sop) seen <= 1'b1;
    end
  end

  assert_stall_bound_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !in_ready |-> low_cnt <= 4'd7);
  assert_stall_len_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(in_ready) |-> (low_cnt == 4'd8) && out_valid && out_sop);
  assert_stall_start_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && in_sop && seen) |=> !in_ready);
  assert_pass_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && !in_sop) |=> out_valid && !out_sop && out_data == $past(in_data));
  assert_first_sync_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && in_sop && !seen) |=> out_valid && out_sop && in_ready && out_data == $past(in_data));
  assert_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (in_ready && !in_valid) |=> !out_valid);
endmodule

bind pkt_parity_sync_enc pkt_parity_sync_enc_chk u_chk (.*);

// File: tb/pkt_parity_sync_enc_tb_top.sv
module pkt_parity_sync_enc_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0, in_sop = 1'b0;
  logic [7:0] in_data = '0;
  logic in_ready, out_valid, out_sop;
  logic [7:0] out_data;

  always #10 clk = ~clk;

  pkt_parity_sync_enc dut_i (.*);

  int n_chk = 0, n_fail = 0, stalls = 0, n_out = 0;
  logic log_en = 1'b0;
  logic [7:0] out_b [0:2047];
  logic       out_s [0:2047];
  logic [7:0] win [0:187];

  localparam int NV = 7;
  localparam logic [15:0] VEC [0:NV-1] = '{16'h1205, 16'h0000, 16'hA53B, 16'hFF00,
                                           16'hA53B, 16'h0101, 16'h8017};

  task automatic chk(input string req, input logic ok, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  always @(negedge clk)
    if (log_en && rst_n && out_valid) begin
      out_b[n_out] = out_data;
      out_s[n_out] = out_sop;
      n_out++;
    end

  initial begin
    for (int c = 0; c < 100000; c++) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  function automatic logic [7:0] pay(input int v, input int i);
    return VEC[v][15:8] + 8'(i) * VEC[v][7:0];
  endfunction

  function automatic logic [7:0] synd();
    logic x [0:1503];
    logic y [0:1503];
    logic r;
    for (int t = 0; t < 1504; t++) x[t] = win[t/8][7 - (t%8)];
    for (int t = 0; t < 1504; t++) begin
      r = x[t];
      if (t >= 1497) r = r ^ x[t-1497];
      if (t >= 1498) r = r ^ x[t-1498];
      if (t >= 1500) r = r ^ x[t-1500];
      if (t >= 1) r = r ^ y[t-1];
      if (t >= 5) r = r ^ y[t-5];
      if (t >= 6) r = r ^ y[t-6];
      if (t >= 8) r = r ^ y[t-8];
      y[t] = r;
    end
    return {y[1496], y[1497], y[1498], y[1499], y[1500], y[1501], y[1502], y[1503]};
  endfunction

  function automatic logic [7:0] enc_model(input int v);
    logic [7:0] s, c;
    for (int i = 0; i < 187; i++) win[i] = pay(v, i);
    win[187] = 8'h00;
    s = synd();
    for (int i = 0; i < 8; i++) begin
      c[7-i] = s[7-i];
      if (i >= 1) c[7-i] = c[7-i] ^ s[7-(i-1)];
      if (i >= 5) c[7-i] = c[7-i] ^ s[7-(i-5)];
      if (i >= 6) c[7-i] = c[7-i] ^ s[7-(i-6)];
    end
    return c ^ 8'h67;
  endfunction

  task automatic send(input logic [7:0] b, input logic s);
    in_valid = 1'b1; in_data = b; in_sop = s;
    forever begin
      if (in_ready) begin @(negedge clk); break; end
      stalls++;
      @(negedge clk);
    end
    in_valid = 1'b0; in_sop = 1'b0;
  endtask

  initial begin
    int base, bad;
    logic [7:0] e;
    @(negedge clk); @(negedge clk);
    chk("R1 reset held", !out_valid && in_ready, {out_valid, in_ready}, 2'b01);
    rst_n = 1'b1;
    log_en = 1'b1;
    @(negedge clk);
    chk("R1 after release", !out_valid && in_ready, {out_valid, in_ready}, 2'b01);

    for (int v = 0; v < NV; v++) begin
      send(8'h47, 1'b1);
      stalls = 0;
      send(pay(v, 0), 1'b0);
      if (v == 0) chk("R3 no stall on first sync", stalls == 0, stalls, 0);
      else        chk("R4 stall length", stalls == 8, stalls, 8);
      for (int i = 1; i < 187; i++) send(pay(v, i), 1'b0);
    end
    send(8'h47, 1'b1);
    stalls = 0;
    while (!in_ready) begin stalls++; @(negedge clk); end
    chk("R4 flush stall length", stalls == 8, stalls, 8);
    for (int c = 0; c < 4; c++) begin
      @(negedge clk);
      chk("R8 idle no output", !out_valid, out_valid, 0);
    end
    log_en = 1'b0;

    chk("R2 output count", n_out == NV*188 + 1, n_out, NV*188 + 1);
    for (int v = 0; v <= NV; v++) begin
      base = v*188;
      if (v < NV) begin
        bad = 0;
        for (int i = 0; i < 187; i++)
          if (out_b[base+1+i] !== pay(v, i) || out_s[base+1+i] !== 1'b0) bad++;
        chk("R2 payload pass-through", bad == 0, bad, 0);
      end
      chk("R4 sop marker on slot", out_s[base] === 1'b1, out_s[base], 1);
      if (v == 0) chk("R3 first slot is 0x47", out_b[base] == 8'h47, out_b[base], 8'h47);
      else begin
        e = enc_model(v-1);
        chk("R5 checksum value", out_b[base] == e, out_b[base], e);
        for (int i = 0; i < 188; i++) win[i] = out_b[base-187+i];
        e = synd();
        chk("R6 window decodes", e == 8'h47, e, 8'h47);
      end
    end
    chk("R5 all-zero payload gives 0x67", out_b[2*188] == 8'h67, out_b[2*188], 8'h67);
    chk("R7 same payload same checksum", out_b[3*188] == out_b[5*188], out_b[5*188], out_b[3*188]);

    for (int i = 0; i < 20; i++) send(8'(i*7), 1'b0);
    rst_n = 1'b0;
    @(negedge clk); @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 reset mid-stream", !out_valid && in_ready, {out_valid, in_ready}, 2'b01);
    send(8'h47, 1'b1);
    chk("R3 first sync after reset", out_valid && out_sop && out_data == 8'h47 && in_ready,
        {out_valid, out_sop, in_ready, out_data}, {3'b111, 8'h47});
    stalls = 0;
    send(8'h5A, 1'b0);
    chk("R3 no stall after reset sync", stalls == 0, stalls, 0);
    chk("R2 byte after reset sync", out_valid && !out_sop && out_data == 8'h5A, out_data, 8'h5A);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule